// File: doc/BRIEF.md
# Texture Page Translation Buffer

This block translates virtual texture addresses issued by one texture filtering unit into physical addresses in local graphics memory. Pages are 4 KiB: the low 12 address bits pass through unchanged, and the virtual page number above them is looked up in a small fully associative buffer. Texture fetches are highly coherent, so the default buffer has only two entries, which are replaced in round-robin order. An invalidate-all input empties the buffer.

On a miss the block stalls the requester and walks a flat page table held in local memory. It does this without the host, using a simple read/write table port. The entry for virtual page `v` sits at word address `TBL_BASE + v`. If the entry is resident, its physical page is used directly. If it is not resident, the block raises a page-in request, or an interrupt request when the interrupt mode input is set, and waits for the servicing agent to return the physical page it filled. In both cases the block then writes the entry back as resident, with its reference count incremented, and installs the translation. The stalled lookup then completes as a hit.

Top module: `tex_page_tlb`

## Requirements
- R1: After reset the buffer holds no translations: `lk_ready`, `rsp_valid`, `tbl_rd_req`, `tbl_wr_en`, `fault_req` and `fault_irq` are all low while no lookup is presented.
- R2: A lookup whose page is cached is accepted in the cycle it is presented (`lk_ready` high). In the next cycle `rsp_valid` is high and `rsp_paddr` = {physical page, `lk_vaddr[11:0]`}.
- R3: A lookup whose page is not cached holds `lk_ready` low and issues one table read at address `TBL_BASE + vpn`, where vpn = `lk_vaddr[VA_W-1:12]`.
- R4: A table entry holds the physical page number in bits [PPN_W-1:0], the resident flag in bit PPN_W, and the reference count in the bits above.
- R5: When the entry read is resident, the block writes back to the same address the same physical page, the resident flag set, and the reference count plus one. It installs the translation, and the stalled lookup then completes with that page.
- R6: When the entry read is not resident and `irq_mode` is low, `fault_req` rises with `fault_vpn` = vpn and holds until `fault_done`. The page on `fault_ppn` in the `fault_done` cycle is written back as resident with the count plus one, and it is used for the lookup.
- R7: When `irq_mode` is high as a non-resident entry is read, `fault_irq` is raised instead of `fault_req`, with the same hold and completion behaviour.
- R8: With ENTRIES=2, installs fill entries in round-robin order. A third distinct page evicts the earlier of the two, and at most one entry ever matches a lookup.
- R9: A pulse on `flush_all` discards every cached translation, so the next lookup of a previously cached page walks the table again.
- R10: The written-back reference count saturates at its all-ones value instead of wrapping.
- R11: `tbl_rd_req` lasts exactly one cycle per walk, and it is never high in the same cycle as `tbl_wr_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_valid | input | 1 | Lookup presented |
| lk_vaddr | input | VPN_W+12 | Virtual texture address |
| lk_ready | output | 1 | Lookup accepted this cycle (hit, no walk active) |
| rsp_valid | output | 1 | Translation result valid |
| rsp_paddr | output | PPN_W+12 | Physical address |
| flush_all | input | 1 | Invalidate all cached translations |
| irq_mode | input | 1 | Report non-resident pages as interrupt requests |
| tbl_rd_req | output | 1 | Page-table read strobe |
| tbl_addr | output | TBL_AW | Page-table word address for read and write |
| tbl_rd_vld | input | 1 | Page-table read data valid |
| tbl_rd_data | input | PTE_W | Page-table entry read |
| tbl_wr_en | output | 1 | Page-table write strobe |
| tbl_wr_data | output | PTE_W | Page-table entry written back |
| fault_req | output | 1 | Page-in request to the transfer engine |
| fault_irq | output | 1 | Page-in request routed as host interrupt |
| fault_vpn | output | VPN_W | Faulting virtual page |
| fault_done | input | 1 | Fault serviced, page available |
| fault_ppn | input | PPN_W | Physical page filled by the servicing agent |

## Verification
The embedded properties assume a well-behaved requester and environment. The requester holds `lk_vaddr` steady while `lk_valid` is high and `lk_ready` is low. The table returns exactly one `tbl_rd_vld` per read strobe. `fault_done` is pulsed only while a fault line is raised. The bench keeps to these assumptions in three ways. Its lookup task changes the address only after acceptance. Its table model answers each strobe once, after a fixed two-cycle latency. Its fault servicer answers only after it observes a raised fault line.

// File: rtl/tptlb_pkg.sv
package tptlb_pkg;

    localparam int PAGE_BITS = 12;

    typedef enum logic [2:0] {
        WK_IDLE,
        WK_READ,
        WK_WAIT,
        WK_FAULT,
        WK_WRITE
    } walk_state_e;

    function automatic logic [31:0] sat_inc(input logic [31:0] v, input logic [31:0] maxv);
        if (v >= maxv) return maxv;
        return v + 32'd1;
    endfunction

endpackage

// File: rtl/tptlb_entries.sv
module tptlb_entries #(
    parameter int VPN_W   = 12,
    parameter int PPN_W   = 10,
    parameter int ENTRIES = 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               flush,
    input  logic [VPN_W-1:0]   look_vpn,
    output logic               hit,
    output logic [PPN_W-1:0]   hit_ppn,
    output logic [ENTRIES-1:0] hit_vec,
    input  logic               ins_en,
    input  logic [VPN_W-1:0]   ins_vpn,
    input  logic [PPN_W-1:0]   ins_ppn
);
    localparam int PTR_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

    logic [PTR_W-1:0] victim;
    logic [PPN_W-1:0] ppn_arr [ENTRIES];

    for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
        logic             v;
        logic [VPN_W-1:0] tag;
        logic [PPN_W-1:0] ppn;

        always_ff @(posedge clk) begin
            if (rst || flush) begin
                v <= 1'b0;
            end else if (ins_en && victim == PTR_W'(g)) begin
                v   <= 1'b1;
                tag <= ins_vpn;
                ppn <= ins_ppn;
            end
        end

        assign hit_vec[g] = v && (tag == look_vpn);
        assign ppn_arr[g] = ppn;
    end

    always_comb begin
        hit_ppn = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (hit_vec[i]) hit_ppn = hit_ppn | ppn_arr[i];
        end
    end

    assign hit = |hit_vec;

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            victim <= '0;
        end else if (ins_en) begin
            victim <= (victim == PTR_W'(ENTRIES - 1)) ? '0 : victim + PTR_W'(1);
        end
    end

    // R8: entries never alias, so a lookup matches at most one slot
    assert_single_match_R8: assert property (@(posedge clk) disable iff (rst)
        $onehot0(hit_vec));

endmodule

// File: rtl/tptlb_walker.sv
module tptlb_walker
    import tptlb_pkg::*;
#(
    parameter int VPN_W  = 12,
    parameter int PPN_W  = 10,
    parameter int REF_W  = 4,
    parameter int TBL_AW = 16,
    parameter logic [TBL_AW-1:0] TBL_BASE = '0,
    localparam int PTE_W = REF_W + 1 + PPN_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              miss,
    input  logic [VPN_W-1:0]  miss_vpn,
    input  logic              irq_mode,
    output logic              idle,
    output logic              tbl_rd_req,
    output logic [TBL_AW-1:0] tbl_addr,
    input  logic              tbl_rd_vld,
    input  logic [PTE_W-1:0]  tbl_rd_data,
    output logic              tbl_wr_en,
    output logic [PTE_W-1:0]  tbl_wr_data,
    output logic              fault_req,
    output logic              fault_irq,
    output logic [VPN_W-1:0]  fault_vpn,
    input  logic              fault_done,
    input  logic [PPN_W-1:0]  fault_ppn,
    output logic              ins_en,
    output logic [VPN_W-1:0]  ins_vpn,
    output logic [PPN_W-1:0]  ins_ppn
);
    localparam int RES_BIT = PPN_W;
    localparam logic [31:0] REF_MAX = 32'((64'd1 << REF_W) - 64'd1);

    walk_state_e      state;
    logic [VPN_W-1:0] cur_vpn;
    logic [PPN_W-1:0] cur_ppn;
    logic [REF_W-1:0] cur_ref;
    logic             irq_sel;
    logic [REF_W-1:0] new_ref;

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= WK_IDLE;
            irq_sel <= 1'b0;
        end else begin
            case (state)
                WK_IDLE: if (miss) begin
                    cur_vpn <= miss_vpn;
                    state   <= WK_READ;
                end
                WK_READ: state <= WK_WAIT;
                WK_WAIT: if (tbl_rd_vld) begin
                    cur_ppn <= tbl_rd_data[PPN_W-1:0];
                    cur_ref <= tbl_rd_data[PTE_W-1:RES_BIT+1];
                    if (tbl_rd_data[RES_BIT]) begin
                        state <= WK_WRITE;
                    end else begin
                        irq_sel <= irq_mode;
                        state   <= WK_FAULT;
                    end
                end
                WK_FAULT: if (fault_done) begin
                    cur_ppn <= fault_ppn;
                    state   <= WK_WRITE;
                end
                WK_WRITE: state <= WK_IDLE;
                default:  state <= WK_IDLE;
            endcase
        end
    end

    assign new_ref     = REF_W'(sat_inc(32'(cur_ref), REF_MAX));
    assign idle        = (state == WK_IDLE);
    assign tbl_rd_req  = (state == WK_READ);
    assign tbl_wr_en   = (state == WK_WRITE);
    assign tbl_addr    = TBL_BASE + TBL_AW'(cur_vpn);
    assign tbl_wr_data = {new_ref, 1'b1, cur_ppn};
    assign fault_req   = (state == WK_FAULT) && !irq_sel;
    assign fault_irq   = (state == WK_FAULT) && irq_sel;
    assign fault_vpn   = cur_vpn;
    assign ins_en      = (state == WK_WRITE);
    assign ins_vpn     = cur_vpn;
    assign ins_ppn     = cur_ppn;

    // R11: table port never reads and writes together
    assert_rd_wr_exclusive_R11: assert property (@(posedge clk) disable iff (rst)
        !(tbl_rd_req && tbl_wr_en));

    // R11: a read strobe lasts a single cycle
    assert_rd_single_cycle_R11: assert property (@(posedge clk) disable iff (rst)
        tbl_rd_req |=> !tbl_rd_req);

    // R6: page-in request and page number hold until serviced
    assert_fault_hold_R6: assert property (@(posedge clk) disable iff (rst)
        (fault_req && !fault_done) |=> (fault_req && $stable(fault_vpn)));

    // R7: only one fault route is active at a time
    assert_fault_route_R7: assert property (@(posedge clk) disable iff (rst)
        !(fault_req && fault_irq));

    // R5: every write-back marks the entry resident
    assert_wb_resident_R5: assert property (@(posedge clk) disable iff (rst)
        tbl_wr_en |-> tbl_wr_data[RES_BIT]);

endmodule

// File: rtl/tex_page_tlb.sv
module tex_page_tlb
    import tptlb_pkg::*;
#(
    parameter int VPN_W   = 12,
    parameter int PPN_W   = 10,
    parameter int REF_W   = 4,
    parameter int ENTRIES = 2,
    parameter int TBL_AW  = 16,
    parameter logic [TBL_AW-1:0] TBL_BASE = 16'h1000,
    localparam int VA_W  = VPN_W + PAGE_BITS,
    localparam int PA_W  = PPN_W + PAGE_BITS,
    localparam int PTE_W = REF_W + 1 + PPN_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              lk_valid,
    input  logic [VA_W-1:0]   lk_vaddr,
    output logic              lk_ready,
    output logic              rsp_valid,
    output logic [PA_W-1:0]   rsp_paddr,
    input  logic              flush_all,
    input  logic              irq_mode,
    output logic              tbl_rd_req,
    output logic [TBL_AW-1:0] tbl_addr,
    input  logic              tbl_rd_vld,
    input  logic [PTE_W-1:0]  tbl_rd_data,
    output logic              tbl_wr_en,
    output logic [PTE_W-1:0]  tbl_wr_data,
    output logic              fault_req,
    output logic              fault_irq,
    output logic [VPN_W-1:0]  fault_vpn,
    input  logic              fault_done,
    input  logic [PPN_W-1:0]  fault_ppn
);
    logic [VPN_W-1:0]   look_vpn;
    logic               hit;
    logic [PPN_W-1:0]   hit_ppn;
    logic [ENTRIES-1:0] hit_vec;
    logic               walk_idle;
    logic               ins_en;
    logic [VPN_W-1:0]   ins_vpn;
    logic [PPN_W-1:0]   ins_ppn;
    logic               miss;

    assign look_vpn = lk_vaddr[VA_W-1:PAGE_BITS];
    assign miss     = lk_valid && !hit;
    assign lk_ready = walk_idle && hit;

    tptlb_entries #(.VPN_W(VPN_W), .PPN_W(PPN_W), .ENTRIES(ENTRIES)) entries_i (
        .clk      (clk),
        .rst      (rst),
        .flush    (flush_all),
        .look_vpn (look_vpn),
        .hit      (hit),
        .hit_ppn  (hit_ppn),
        .hit_vec  (hit_vec),
        .ins_en   (ins_en),
        .ins_vpn  (ins_vpn),
        .ins_ppn  (ins_ppn)
    );

    tptlb_walker #(.VPN_W(VPN_W), .PPN_W(PPN_W), .REF_W(REF_W),
                   .TBL_AW(TBL_AW), .TBL_BASE(TBL_BASE)) walker_i (
        .clk         (clk),
        .rst         (rst),
        .miss        (miss),
        .miss_vpn    (look_vpn),
        .irq_mode    (irq_mode),
        .idle        (walk_idle),
        .tbl_rd_req  (tbl_rd_req),
        .tbl_addr    (tbl_addr),
        .tbl_rd_vld  (tbl_rd_vld),
        .tbl_rd_data (tbl_rd_data),
        .tbl_wr_en   (tbl_wr_en),
        .tbl_wr_data (tbl_wr_data),
        .fault_req   (fault_req),
        .fault_irq   (fault_irq),
        .fault_vpn   (fault_vpn),
        .fault_done  (fault_done),
        .fault_ppn   (fault_ppn),
        .ins_en      (ins_en),
        .ins_vpn     (ins_vpn),
        .ins_ppn     (ins_ppn)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid <= 1'b0;
        end else begin
            rsp_valid <= lk_valid && lk_ready;
            if (lk_valid && lk_ready) rsp_paddr <= {hit_ppn, lk_vaddr[PAGE_BITS-1:0]};
        end
    end

    // R2: an accepted lookup answers in the following cycle
    assert_rsp_after_accept_R2: assert property (@(posedge clk) disable iff (rst)
        (lk_valid && lk_ready) |=> rsp_valid);

    // R3: no lookup is accepted while a table walk is in flight
    assert_stall_during_walk_R3: assert property (@(posedge clk) disable iff (rst)
        (tbl_rd_req || tbl_wr_en || fault_req || fault_irq) |-> !lk_ready);

    // R2: no response without a prior acceptance
    assert_no_spurious_rsp_R2: assert property (@(posedge clk) disable iff (rst)
        !$past(lk_valid && lk_ready) |-> !rsp_valid);

endmodule

// File: tb/tex_page_tlb_tb_top.sv
module tex_page_tlb_tb_top;
    localparam int VPN_W = 12, PPN_W = 10, REF_W = 4, TBL_AW = 16;
    localparam int VA_W = VPN_W + 12, PA_W = PPN_W + 12, PTE_W = REF_W + 1 + PPN_W;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic lk_valid = 1'b0;
    logic [VA_W-1:0] lk_vaddr = '0;
    logic lk_ready, rsp_valid;
    logic [PA_W-1:0] rsp_paddr;
    logic flush_all = 1'b0, irq_mode = 1'b0;
    logic tbl_rd_req, tbl_wr_en, fault_req, fault_irq;
    logic [TBL_AW-1:0] tbl_addr;
    logic tbl_rd_vld = 1'b0;
    logic [PTE_W-1:0] tbl_rd_data = '0;
    logic [PTE_W-1:0] tbl_wr_data;
    logic [VPN_W-1:0] fault_vpn;
    logic fault_done = 1'b0;
    logic [PPN_W-1:0] fault_ppn = '0;

    int errors = 0, checks = 0;

    always #10 clk = ~clk;

    tex_page_tlb dut_i (
        .clk(clk), .rst(rst), .lk_valid(lk_valid), .lk_vaddr(lk_vaddr),
        .lk_ready(lk_ready), .rsp_valid(rsp_valid), .rsp_paddr(rsp_paddr),
        .flush_all(flush_all), .irq_mode(irq_mode),
        .tbl_rd_req(tbl_rd_req), .tbl_addr(tbl_addr), .tbl_rd_vld(tbl_rd_vld),
        .tbl_rd_data(tbl_rd_data), .tbl_wr_en(tbl_wr_en), .tbl_wr_data(tbl_wr_data),
        .fault_req(fault_req), .fault_irq(fault_irq), .fault_vpn(fault_vpn),
        .fault_done(fault_done), .fault_ppn(fault_ppn)
    );

    // page-table memory model, two-cycle read latency
    logic [PTE_W-1:0] mem [64];
    logic p1 = 1'b0;
    logic [TBL_AW-1:0] a1 = '0;
    int rd_cnt = 0, wr_cnt = 0, overlap_cnt = 0, long_rd_cnt = 0;
    logic prev_rd = 1'b0;
    logic [TBL_AW-1:0] last_rd_addr = '0, last_wr_addr = '0;
    logic [PTE_W-1:0] last_wr_data = '0;

    initial begin
        forever begin
            @(posedge clk);
            p1 <= tbl_rd_req;
            a1 <= tbl_addr;
            tbl_rd_vld <= p1;
            tbl_rd_data <= mem[a1[5:0]];
            prev_rd <= tbl_rd_req;
            if (!rst) begin
                if (tbl_rd_req) begin rd_cnt++; last_rd_addr <= tbl_addr; end
                if (tbl_rd_req && prev_rd) long_rd_cnt++;
                if (tbl_rd_req && tbl_wr_en) overlap_cnt++;
                if (tbl_wr_en) begin
                    wr_cnt++;
                    last_wr_addr <= tbl_addr;
                    last_wr_data <= tbl_wr_data;
                    mem[tbl_addr[5:0]] <= tbl_wr_data;
                end
            end
        end
    end

    // fault servicer
    logic [PPN_W-1:0] svc_ppn = '0;
    int saw_req = 0, saw_irq = 0;
    logic [VPN_W-1:0] saw_vpn = '0;
    initial begin
        forever begin
            @(negedge clk);
            if (fault_req || fault_irq) begin
                if (fault_req) saw_req++;
                if (fault_irq) saw_irq++;
                saw_vpn = fault_vpn;
                repeat (3) @(negedge clk);
                fault_ppn  = svc_ppn;
                fault_done = 1'b1;
                @(negedge clk);
                fault_done = 1'b0;
            end
        end
    end

    function automatic logic [PTE_W-1:0] mk(input int r, input bit res, input int p);
        return {REF_W'(r), res, PPN_W'(p)};
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    task automatic lookup(input logic [VA_W-1:0] va, output int stall, output logic [PA_W-1:0] pa);
        stall = 0;
        lk_vaddr = va;
        lk_valid = 1'b1;
        #1;
        while (!lk_ready && stall < 200) begin
            @(negedge clk);
            stall++;
        end
        @(negedge clk);
        lk_valid = 1'b0;
        check(rsp_valid == 1'b1, "R2", "rsp_valid after accept", 64'(rsp_valid), 1);
        pa = rsp_paddr;
    endtask

    task automatic t_reset();
        check(!lk_ready && !rsp_valid, "R1", "ready/rsp idle", {lk_ready, rsp_valid}, 0);
        check(!tbl_rd_req && !tbl_wr_en, "R1", "table port idle", {tbl_rd_req, tbl_wr_en}, 0);
        check(!fault_req && !fault_irq, "R1", "fault lines idle", {fault_req, fault_irq}, 0);
    endtask

    task automatic t_resident_miss();
        int st; logic [PA_W-1:0] pa; int r0 = rd_cnt;
        mem[5] = mk(2, 1, 'h123);
        lookup(24'h005ABC, st, pa);
        check(st > 0, "R3", "miss stalls", st, 1);
        check(rd_cnt == r0 + 1, "R3", "one table read", rd_cnt - r0, 1);
        check(last_rd_addr == 16'h1005, "R3", "read address", last_rd_addr, 'h1005);
        check(pa == {10'h123, 12'hABC}, "R5", "refilled paddr", pa, {10'h123, 12'hABC});
        check(last_wr_addr == 16'h1005, "R5", "write address", last_wr_addr, 'h1005);
        check(last_wr_data == mk(3, 1, 'h123), "R4", "write-back entry", last_wr_data, mk(3, 1, 'h123));
    endtask

    task automatic t_hit();
        int st; logic [PA_W-1:0] pa; int r0 = rd_cnt;
        lookup(24'h005007, st, pa);
        check(st == 0, "R2", "hit accepted at once", st, 0);
        check(pa == {10'h123, 12'h007}, "R2", "hit paddr", pa, {10'h123, 12'h007});
        check(rd_cnt == r0, "R2", "no table read on hit", rd_cnt - r0, 0);
    endtask

    task automatic t_fault_req();
        int st; logic [PA_W-1:0] pa;
        mem[7] = mk(0, 0, 0);
        svc_ppn = 'h2AA;
        saw_req = 0; saw_irq = 0;
        lookup(24'h007010, st, pa);
        check(saw_req == 1 && saw_irq == 0, "R6", "page-in request line", {saw_req, saw_irq}, 'h100000000);
        check(saw_vpn == 7, "R6", "fault vpn", saw_vpn, 7);
        check(pa == {10'h2AA, 12'h010}, "R6", "paddr from fault service", pa, {10'h2AA, 12'h010});
        check(last_wr_data == mk(1, 1, 'h2AA), "R6", "write-back after fault", last_wr_data, mk(1, 1, 'h2AA));
    endtask

    task automatic t_round_robin();
        int st; logic [PA_W-1:0] pa;
        mem[9] = mk(0, 1, 'h099);
        lookup(24'h009000, st, pa);
        check(st > 0 && pa == {10'h099, 12'h000}, "R8", "third page installed", pa, {10'h099, 12'h000});
        lookup(24'h007444, st, pa);
        check(st == 0, "R8", "newer page kept", st, 0);
        lookup(24'h005444, st, pa);
        check(st > 0, "R8", "oldest page evicted", st, 1);
    endtask

    task automatic t_irq_mode();
        int st; logic [PA_W-1:0] pa;
        mem[11] = mk(0, 0, 0);
        svc_ppn = 'h311;
        irq_mode = 1'b1;
        saw_req = 0; saw_irq = 0;
        lookup(24'h00B020, st, pa);
        irq_mode = 1'b0;
        check(saw_irq == 1 && saw_req == 0, "R7", "interrupt line used", {saw_irq, saw_req}, 'h100000000);
        check(pa == {10'h311, 12'h020}, "R7", "paddr after interrupt service", pa, {10'h311, 12'h020});
    endtask

    task automatic t_saturate();
        int st; logic [PA_W-1:0] pa;
        mem[12] = mk(15, 1, 'h0F0);
        lookup(24'h00C001, st, pa);
        check(last_wr_data == mk(15, 1, 'h0F0), "R10", "count saturates", last_wr_data, mk(15, 1, 'h0F0));
    endtask

    task automatic t_flush();
        int st; logic [PA_W-1:0] pa; int r0;
        lookup(24'h00C002, st, pa);
        check(st == 0, "R9", "cached before flush", st, 0);
        flush_all = 1'b1;
        @(negedge clk);
        flush_all = 1'b0;
        r0 = rd_cnt;
        lookup(24'h00C003, st, pa);
        check(st > 0 && rd_cnt == r0 + 1, "R9", "walk after flush", rd_cnt - r0, 1);
        check(pa == {10'h0F0, 12'h003}, "R9", "paddr after flush", pa, {10'h0F0, 12'h003});
    endtask

    initial begin
        for (int i = 0; i < 64; i++) mem[i] = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_resident_miss();
        t_hit();
        t_fault_req();
        t_round_robin();
        t_irq_mode();
        t_saturate();
        t_flush();
        check(overlap_cnt == 0, "R11", "read/write overlap", overlap_cnt, 0);
        check(long_rd_cnt == 0, "R11", "read strobe length", long_rd_cnt, 0);
        finish_run();
    end

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_run();
    end

endmodule